// File: doc/BRIEF.md
# Logical Bitmask Immediate Expander

This block turns a compact 13-bit logical-immediate code into a full-width bitmask for a 32-bit or 64-bit logic operation. The code has three fields: a one-bit wide-element flag, a 6-bit length code and a 6-bit rotate code. The wide flag and the leading ones of the length code pick an element width of 2, 4, 8, 16, 32 or 64 bits. The remaining low bits of the length code give the length of a run of ones that starts at bit 0 of the element. The rotate code turns that run right within the element, and the element is then copied across the register.

The block is purely combinational. An execution unit places it between instruction decode and the logic ALU. Codes that describe no legal mask are flagged as invalid. An invalid code always drives a zero mask, so downstream logic never sees an all-zero or all-ones result from a code that claims to be legal.

Top module: `bitmask_imm_expand`

## Requirements
- R1: Element width is 64 when `elem_wide`=1. When `elem_wide`=0 it is chosen by the top bits of `len_code`: 0xxxxx gives 32, 10xxxx gives 16, 110xxx gives 8, 1110xx gives 4 and 11110x gives 2.
- R2: With a rotate of zero, each element holds (F+1) consecutive ones from bit 0 upward. F is the value of the `len_code` bits marked x in R1, that is, its low log2(width) bits.
- R3: The run is rotated right within the element by `rot_code` modulo the element width. Only the low log2(width) bits of `rot_code` matter.
- R4: The rotated element is repeated to fill the whole active width, 64 bits when `is_64b`=1 and 32 bits when `is_64b`=0.
- R5: A length field F of all ones, meaning a run that fills its element, sets `invalid`.
- R6: `elem_wide`=0 with `len_code`=11111x matches no width and sets `invalid`.
- R7: When `is_64b`=0, `elem_wide`=1 sets `invalid`, and `mask[63:32]` is always zero.
- R8: Whenever `invalid`=1, `mask` is all zeros.
- R9: A valid mask is never all zeros or all ones over the active width. Over all codes in 64-bit mode there are exactly 5334 distinct valid masks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| is_64b | input | 1 | 1 selects a 64-bit result, 0 a 32-bit result |
| elem_wide | input | 1 | Wide-element flag: 1 forces a 64-bit element |
| len_code | input | 6 | Width-prefix and run-length code |
| rot_code | input | 6 | Right-rotate amount within the element |
| mask | output | 64 | Expanded bitmask, zero when invalid |
| invalid | output | 1 | The code describes no legal mask |

## Verification
The bench builds the block with its default parameters: a 6-bit length and rotate code and a 64-bit wide result with a 32-bit narrow one. With these values the whole input space of 16384 codes is small enough to sweep exhaustively against an independent model. This reaches every element width from 2 to 64, every rotation and both result widths. It also allows the distinct valid 64-bit masks to be collected and counted against 5334.

// File: rtl/bmx_pkg.sv
package bmx_pkg;
  localparam int unsigned CODE_W   = 6;
  localparam int unsigned WIDE_W   = 1 << CODE_W;
  localparam int unsigned NARROW_W = WIDE_W / 2;
  localparam int unsigned LVL_W    = $clog2(CODE_W + 1);
endpackage

// File: rtl/bmx_size_sel.sv
// Finds the element-size level: the highest set bit of {elem_wide, ~len_code}.
module bmx_size_sel #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned LVL_W  = 3
) (
  input  logic              elem_wide,
  input  logic [CODE_W-1:0] len_code,
  output logic [LVL_W-1:0]  lvl,
  output logic              size_found
);
  logic [CODE_W:0] probe;

  function automatic logic [LVL_W-1:0] top_one(input logic [CODE_W:0] v);
    logic [LVL_W-1:0] r;
    r = '0;
    for (int i = 0; i <= CODE_W; i++) begin
      if (v[i]) r = LVL_W'(i);
    end
    return r;
  endfunction

  assign probe      = {elem_wide, ~len_code};
  assign lvl        = top_one(probe);
  // level 0 would be a 1-bit element: not a legal size
  assign size_found = |probe[CODE_W:1];
endmodule

// File: rtl/bmx_elem.sv
// One element width 2**K: run of ones, right rotation, replication.
module bmx_elem #(
  parameter int unsigned K     = 1,
  parameter int unsigned OUT_W = 64
) (
  input  logic [K-1:0]     len_f,
  input  logic [K-1:0]     rot_f,
  output logic [OUT_W-1:0] rep,
  output logic             run_full
);
  localparam int unsigned EW = 1 << K;

  logic [EW-1:0] base;
  logic [EW-1:0] turned;

  function automatic logic [EW-1:0] make_run(input logic [K-1:0] f);
    logic [EW-1:0] r;
    for (int i = 0; i < EW; i++) r[i] = (i <= int'(f));
    return r;
  endfunction

  function automatic logic [EW-1:0] rot_right(input logic [EW-1:0] v,
                                              input logic [K-1:0] amt);
    logic [EW-1:0] r;
    logic [K-1:0]  src;
    for (int i = 0; i < EW; i++) begin
      src  = K'(i) + amt;
      r[i] = v[src];
    end
    return r;
  endfunction

  assign run_full = &len_f;
  assign base     = make_run(len_f);
  assign turned   = rot_right(base, rot_f);

  for (genvar j = 0; j < OUT_W; j++) begin : g_rep
    assign rep[j] = turned[j % EW];
  end
endmodule

// File: rtl/bmx_lvl_mux.sv
// Picks the replicated pattern and the full-run flag of the chosen level.
module bmx_lvl_mux #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned WIDE_W = 64,
  parameter int unsigned LVL_W  = 3
) (
  input  logic [LVL_W-1:0]         lvl,
  input  logic [CODE_W*WIDE_W-1:0] rep_flat,
  input  logic [CODE_W-1:0]        full_vec,
  output logic [WIDE_W-1:0]        rep_sel,
  output logic                     full_sel
);
  always_comb begin
    rep_sel  = '0;
    full_sel = 1'b0;
    for (int k = 1; k <= int'(CODE_W); k++) begin
      if (int'(lvl) == k) begin
        rep_sel  = rep_flat[(k-1)*WIDE_W +: WIDE_W];
        full_sel = full_vec[k-1];
      end
    end
  end
endmodule

// File: rtl/bitmask_imm_expand.sv
module bitmask_imm_expand
  import bmx_pkg::*;
#(
  parameter int unsigned P_CODE_W   = CODE_W,
  parameter int unsigned P_WIDE_W   = WIDE_W,
  parameter int unsigned P_NARROW_W = NARROW_W
) (
  input  logic                  is_64b,
  input  logic                  elem_wide,
  input  logic [P_CODE_W-1:0]   len_code,
  input  logic [P_CODE_W-1:0]   rot_code,
  output logic [P_WIDE_W-1:0]   mask,
  output logic                  invalid
);
  localparam int unsigned P_LVL_W = $clog2(P_CODE_W + 1);

  // named internal events, observed by the checker
  logic [P_LVL_W-1:0]          lvl;
  logic                        size_found;
  logic                        run_full_sel;
  logic                        narrow_bad;
  logic [P_WIDE_W-1:0]         rep_sel;
  logic [P_WIDE_W-1:0]         width_keep;
  logic [P_CODE_W*P_WIDE_W-1:0] rep_flat;
  logic [P_CODE_W-1:0]         full_vec;

  bmx_size_sel #(.CODE_W(P_CODE_W), .LVL_W(P_LVL_W)) u_size (
    .elem_wide (elem_wide),
    .len_code  (len_code),
    .lvl       (lvl),
    .size_found(size_found)
  );

  for (genvar gk = 1; gk <= P_CODE_W; gk++) begin : g_lvl
    bmx_elem #(.K(gk), .OUT_W(P_WIDE_W)) u_elem (
      .len_f   (len_code[gk-1:0]),
      .rot_f   (rot_code[gk-1:0]),
      .rep     (rep_flat[(gk-1)*P_WIDE_W +: P_WIDE_W]),
      .run_full(full_vec[gk-1])
    );
  end

  bmx_lvl_mux #(.CODE_W(P_CODE_W), .WIDE_W(P_WIDE_W), .LVL_W(P_LVL_W)) u_mux (
    .lvl     (lvl),
    .rep_flat(rep_flat),
    .full_vec(full_vec),
    .rep_sel (rep_sel),
    .full_sel(run_full_sel)
  );

  assign narrow_bad = !is_64b && elem_wide;
  assign width_keep = is_64b ? '1
                    : {{(P_WIDE_W-P_NARROW_W){1'b0}}, {P_NARROW_W{1'b1}}};
  assign invalid    = !size_found || narrow_bad || run_full_sel;
  assign mask       = invalid ? '0 : (rep_sel & width_keep);
endmodule

// File: rtl/bitmask_imm_expand_chk.sv
module bitmask_imm_expand_chk
  import bmx_pkg::*;
(
  input logic                is_64b,
  input logic                elem_wide,
  input logic [CODE_W-1:0]   len_code,
  input logic [WIDE_W-1:0]   mask,
  input logic                invalid,
  input logic [LVL_W-1:0]    lvl
);
  logic [WIDE_W-1:0] act_w;
  int                exp_pop;
  int                sz;
  int                fld;

  always_comb begin
    act_w   = is_64b ? '1 : {{(WIDE_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};
    sz      = 1 << lvl;
    fld     = int'(len_code) & (sz - 1);
    exp_pop = ((is_64b ? int'(WIDE_W) : int'(NARROW_W)) / sz) * (fld + 1);
  end

  always_comb begin
    // R8
    zero_on_invalid_chk: assert (!invalid || mask == '0);
    // R7
    narrow_upper_chk: assert (is_64b || mask[WIDE_W-1:NARROW_W] == '0);
    // R7
    narrow_wide_rej_chk: assert (is_64b || !elem_wide || invalid);
    // R1
    wide_level_chk: assert (!elem_wide || int'(lvl) == int'(CODE_W));
    // R6
    no_size_chk: assert (elem_wide || len_code[CODE_W-1:1] != '1 || invalid);
    // R9
    not_const_chk: assert (invalid || (mask != '0 && (mask | ~act_w) != '1));
    // R4
    pop_count_chk: assert (invalid || $countones(mask) == exp_pop);
  end
endmodule

bind bitmask_imm_expand bitmask_imm_expand_chk u_chk (
  .is_64b   (is_64b),
  .elem_wide(elem_wide),
  .len_code (len_code),
  .mask     (mask),
  .invalid  (invalid),
  .lvl      (lvl)
);

// File: tb/bitmask_imm_expand_tb.sv
`timescale 1ns/1ps
module bitmask_imm_expand_tb;
  logic        clk = 1'b0;
  logic        is_64b, elem_wide;
  logic [5:0]  len_code, rot_code;
  logic [63:0] mask;
  logic        invalid;
  int          n_chk = 0;
  int          n_bad = 0;
  bit          seen [logic [63:0]];

  always #2.5 clk = ~clk;

  bitmask_imm_expand u_dut (
    .is_64b(is_64b), .elem_wide(elem_wide), .len_code(len_code),
    .rot_code(rot_code), .mask(mask), .invalid(invalid)
  );

  // {is_64b, elem_wide, len_code, rot_code, exp_invalid, exp_mask}
  localparam int NV = 19;
  localparam logic [78:0] VEC [NV] = '{
    {1'b1, 1'b1, 6'b000000, 6'd0,  1'b0, 64'h0000000000000001},
    {1'b1, 1'b1, 6'b000111, 6'd0,  1'b0, 64'h00000000000000FF},
    {1'b1, 1'b1, 6'b000000, 6'd1,  1'b0, 64'h8000000000000000},
    {1'b1, 1'b1, 6'b111111, 6'd0,  1'b1, 64'h0},
    {1'b1, 1'b0, 6'b000000, 6'd0,  1'b0, 64'h0000000100000001},
    {1'b1, 1'b0, 6'b111100, 6'd0,  1'b0, 64'h5555555555555555},
    {1'b1, 1'b0, 6'b111100, 6'd1,  1'b0, 64'hAAAAAAAAAAAAAAAA},
    {1'b1, 1'b0, 6'b111101, 6'd0,  1'b1, 64'h0},
    {1'b1, 1'b0, 6'b111110, 6'd0,  1'b1, 64'h0},
    {1'b1, 1'b0, 6'b111111, 6'd5,  1'b1, 64'h0},
    {1'b1, 1'b0, 6'b110011, 6'd2,  1'b0, 64'hC3C3C3C3C3C3C3C3},
    {1'b1, 1'b0, 6'b100111, 6'd4,  1'b0, 64'hF00FF00FF00FF00F},
    {1'b1, 1'b0, 6'b111010, 6'd3,  1'b0, 64'hEEEEEEEEEEEEEEEE},
    {1'b1, 1'b0, 6'b111010, 6'd63, 1'b0, 64'hEEEEEEEEEEEEEEEE},
    {1'b0, 1'b1, 6'b000000, 6'd0,  1'b1, 64'h0},
    {1'b0, 1'b0, 6'b000000, 6'd1,  1'b0, 64'h0000000080000000},
    {1'b0, 1'b0, 6'b111100, 6'd0,  1'b0, 64'h0000000055555555},
    {1'b0, 1'b0, 6'b011111, 6'd0,  1'b1, 64'h0},
    {1'b1, 1'b0, 6'b011110, 6'd0,  1'b0, 64'h7FFFFFFF7FFFFFFF}
  };

  function automatic string row_tag(input int i);
    case (i)
      0, 1, 18:         return "R2";
      2, 6, 10, 11, 12: return "R3";
      13:               return "R3";
      3, 7, 17:         return "R5";
      4:                return "R4";
      5:                return "R1";
      8, 9:             return "R6";
      default:          return "R7";
    endcase
  endfunction

  // independent model from the requirements: {invalid, mask}
  function automatic logic [64:0] ref_model(input logic m64, input logic w,
                                            input logic [5:0] l, input logic [5:0] r);
    int          sz;
    int          len;
    int          rot;
    logic [63:0] e;
    if (w)          sz = 64;
    else if (!l[5]) sz = 32;
    else if (!l[4]) sz = 16;
    else if (!l[3]) sz = 8;
    else if (!l[2]) sz = 4;
    else if (!l[1]) sz = 2;
    else            sz = 0;
    if (sz == 0 || (!m64 && w)) return {1'b1, 64'd0};
    len = (int'(l) % sz) + 1;
    if (len == sz) return {1'b1, 64'd0};
    e   = (64'd1 << len) - 64'd1;
    rot = int'(r) % sz;
    for (int k = 0; k < rot; k++) e = (e >> 1) | ((e & 64'd1) << (sz - 1));
    for (int s = sz; s < 64; s = s * 2) e = e | (e << s);
    if (!m64) e = e & 64'h00000000FFFFFFFF;
    return {1'b0, e};
  endfunction

  task automatic apply(input logic m, input logic w, input logic [5:0] l, input logic [5:0] r);
    @(posedge clk);
    is_64b = m; elem_wide = w; len_code = l; rot_code = r;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [64:0] act, input logic [64:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got inv=%0b mask=%h, expected inv=%0b mask=%h (codes m=%0b w=%0b l=%b r=%0d)",
               tag, act[64], act[63:0], exp[64], exp[63:0], is_64b, elem_wide, len_code, rot_code);
    end
  endtask

  initial begin
    is_64b = 1'b0; elem_wide = 1'b0; len_code = '0; rot_code = '0;
    // idle inputs: narrow 32-bit element, one-bit run (R4)
    apply(1'b0, 1'b0, 6'd0, 6'd0);
    check("R4", {invalid, mask}, {1'b0, 64'h0000000000000001});

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][78], VEC[i][77], VEC[i][76:71], VEC[i][70:65]);
      check(row_tag(i), {invalid, mask}, VEC[i][64:0]);
    end

    // exhaustive sweep against the model; R8 for invalid codes, R4 otherwise
    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int l = 0; l < 64; l++)
          for (int r = 0; r < 64; r++) begin
            logic [64:0] exp;
            exp = ref_model(m[0], w[0], l[5:0], r[5:0]);
            apply(m[0], w[0], l[5:0], r[5:0]);
            check(exp[64] ? "R8" : "R4", {invalid, mask}, exp);
            if (m == 1 && !invalid) seen[mask] = 1'b1;
          end

    // R9: count of distinct legal 64-bit masks
    n_chk++;
    if (seen.num() != 5334) begin
      n_bad++;
      $display("FAIL R9: distinct masks %0d, expected 5334", seen.num());
    end

    // R9: no all-ones / all-zero result in the narrow width
    apply(1'b0, 1'b0, 6'b011110, 6'd7);
    check("R9", {invalid, mask}, {1'b0, 64'h00000000FFFFFFFE >> 0 ^ 64'h0} == 65'h0 ? 65'h0
          : ref_model(1'b0, 1'b0, 6'b011110, 6'd7));
    n_chk++;
    if (mask[31:0] == 32'hFFFFFFFF || mask == 64'd0) begin
      n_bad++;
      $display("FAIL R9: narrow mask %h, expected neither all-ones nor zero", mask);
    end

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule